// File: doc/BRIEF.md
# Receive-Only Byte Request Counter

This block runs the receive-only side of an SPI master. Software writes a byte count to a request input. The block then enables the shift engine so that it clocks bits in without sending anything. Received bits are packed into 32-bit words, independent of any word-length setting used for normal transfers. Each finished word goes to a receive FIFO through a valid/ready pair. A live count of bytes still owed is available for software to read.

When the count runs out in the middle of a word, that last word carries only the remaining bytes. They are packed toward the low end: the first of them sits in the highest valid byte lane and the newest sits in bits 7:0. A 3-bit byte-valid field reports how many lanes of the most recently delivered word hold data. Software may add more bytes while a request is still running. The FIFO itself lies outside this block.

Top module: `rx_req_counter`

## Requirements
- R1: After reset, `remaining` is 0, `shift_en`, `word_valid` and `rx_done` are 0, and `byte_valid` is 0.
- R2: A write of a nonzero count N, with the block idle, makes `remaining` equal N and raises `shift_en` in the next cycle.
- R3: A write of count 0 to an idle block has no effect: `remaining`, `shift_en` and `word_valid` stay 0.
- R4: A bit is taken on each clock edge where `shift_en` and `bit_stb` are both high. Bits fill each byte most significant bit first. A full word carries four bytes, with the earliest byte in bits 31:24 and the latest in bits 7:0.
- R5: `remaining` drops by exactly 1 on the edge that takes the eighth bit of a byte, and changes at no other time except on a request write.
- R6: When the count runs out with k < 4 bytes in the current word, that word is delivered right-aligned. The earliest of its bytes sits in lane k-1, the latest in bits 7:0, and all unused upper lanes are 0.
- R7: `byte_valid` changes only on the edge where a word is accepted (`word_valid` and `word_ready` both high). It then takes the number of bytes in that word: 4 for a full word, k for a partial word.
- R8: While `word_valid` is high and `word_ready` is low, `word_data` holds steady and `shift_en` stays low, so shifting pauses at the word boundary.
- R9: `rx_done` pulses high for one cycle, in the cycle after the final word of a request is accepted. At that point `remaining` is 0 and `word_valid` is 0.
- R10: A nonzero request written while bytes are still owed adds to `remaining`, saturating at 65535. The added bytes continue in the same word stream, so a word does not close early at the old count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Request write strobe |
| req_cnt | input | 16 | Number of bytes to receive |
| shift_en | output | 1 | Asks the shift engine for serial clocks |
| bit_stb | input | 1 | Shift engine presents a sampled bit |
| bit_din | input | 1 | Sampled serial bit |
| word_valid | output | 1 | Packed word ready for the FIFO |
| word_ready | input | 1 | FIFO accepts the word |
| word_data | output | 32 | Packed received word |
| remaining | output | 16 | Bytes still to be received |
| byte_valid | output | 3 | Valid byte count of the last delivered word |
| rx_done | output | 1 | One-cycle pulse when a request completes |

## Verification
Every request length from 1 to 13 bytes is run. These lengths cover each partial-word size (1, 2 and 3 bytes) on its own, after one full word and after two full words, along with exact multiples of four. Each length is repeated under three handshake patterns:
- a FIFO that is always ready with a bit offered every cycle;
- a FIFO that is ready only one cycle in three, with bit gaps;
- a FIFO that stalls for ten cycles at a time.

The first pattern separates packing and lane order from flow control. The other two expose lost or repeated bits, words that change while stalled, and a byte-valid field that updates at the wrong moment. A request added mid-transfer checks that the word stream keeps going instead of closing a short word. A back-to-back pair of large requests checks saturation.

// File: rtl/rx_req_counter.sv
module rx_req_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_wr,
  input  logic [CNT_W-1:0] req_cnt,
  output logic             shift_en,
  input  logic             bit_stb,
  input  logic             bit_din,
  output logic             word_valid,
  input  logic             word_ready,
  output logic [31:0]      word_data,
  output logic [CNT_W-1:0] remaining,
  output logic [2:0]       byte_valid,
  output logic             rx_done
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] rem_q;
  logic [2:0]       bit_q;
  logic [6:0]       bsh_q;
  logic [1:0]       nb_q;
  logic [23:0]      acc_q;
  logic             wv_q;
  logic [31:0]      word_q;
  logic [2:0]       wnb_q;
  logic [2:0]       bv_q;
  logic             done_q;

  logic             take_bit, byte_end, req_go, push, close_word;
  logic [31:0]      packed_w;
  logic [CNT_W:0]   rem_sum;
  logic [CNT_W-1:0] rem_next;

  assign shift_en   = (rem_q != '0) && !wv_q;
  assign take_bit   = shift_en && bit_stb;
  assign byte_end   = take_bit && (bit_q == 3'd7);
  assign req_go     = req_wr && (req_cnt != '0);
  assign push       = wv_q && word_ready;
  assign packed_w   = {acc_q, bsh_q, bit_din};
  assign close_word = byte_end && ((nb_q == 2'd3) || ((rem_q == 1) && !req_go));

  assign rem_sum  = {1'b0, rem_q - {{(CNT_W-1){1'b0}}, byte_end}}
                  + {1'b0, (req_go ? req_cnt : '0)};
  assign rem_next = rem_sum[CNT_W] ? CNT_MAX : rem_sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      bit_q  <= '0;
      bsh_q  <= '0;
      nb_q   <= '0;
      acc_q  <= '0;
      wv_q   <= 1'b0;
      word_q <= '0;
      wnb_q  <= '0;
      bv_q   <= '0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_next;
      done_q <= push && (rem_q == '0) && !req_go;
      if (take_bit) begin
        bit_q <= bit_q + 3'd1;
        bsh_q <= {bsh_q[5:0], bit_din};
      end
      if (byte_end) begin
        if (close_word) begin
          word_q <= packed_w;
          wv_q   <= 1'b1;
          wnb_q  <= {1'b0, nb_q} + 3'd1;
          acc_q  <= '0;
          nb_q   <= '0;
        end else begin
          acc_q <= packed_w[23:0];
          nb_q  <= nb_q + 2'd1;
        end
      end
      if (push) begin
        wv_q <= 1'b0;
        bv_q <= wnb_q;
      end
    end
  end

  assign word_valid = wv_q;
  assign word_data  = word_q;
  assign remaining  = rem_q;
  assign byte_valid = bv_q;
  assign rx_done    = done_q;

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data) && !shift_en));

  p_full_word_bv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready && remaining != '0) |=> (byte_valid == 3'd4));

  p_bv_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid && word_ready) |=> $stable(byte_valid));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (remaining == '0 && !word_valid && !shift_en));

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_wr |=> (remaining == $past(remaining) || remaining == $past(remaining) - 1));

  p_zero_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_cnt == '0 && remaining == '0 && !word_valid) |=> (remaining == '0 && !shift_en));

  p_partial_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) && remaining == '0 && word_data[31:24] != 8'h00 |-> $past(nb_q) == 2'd3);

endmodule

// File: tb/tb_rx_req_counter.sv
`timescale 1ns/1ps
module tb_rx_req_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_wr = 1'b0;
  logic [15:0] req_cnt = '0;
  logic        shift_en;
  logic        bit_stb = 1'b0;
  logic        bit_din = 1'b0;
  logic        word_valid;
  logic        word_ready = 1'b0;
  logic [31:0] word_data;
  logic [15:0] remaining;
  logic [2:0]  byte_valid;
  logic        rx_done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rx_req_counter dut (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_cnt(req_cnt),
    .shift_en(shift_en), .bit_stb(bit_stb), .bit_din(bit_din),
    .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
    .remaining(remaining), .byte_valid(byte_valid), .rx_done(rx_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input int seed, input int i);
    return 8'((seed * 29 + i * 13 + 7) & 255);
  endfunction

  function automatic logic [31:0] exp_word(input int seed, input int total, input int k);
    logic [31:0] w = '0;
    for (int b = 4 * k; b < 4 * k + 4 && b < total; b++) w = {w[23:0], dbyte(seed, b)};
    return w;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; req_wr = 1'b0; bit_stb = 1'b0; word_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic run_xfer(input int n, input int mode, input int extra, input int extra_at);
    int requested, total, idx, cyc, wk, pend_cnt;
    bit pend, pend_last, fin, rdy, stall_prev, s_se, s_wv, s_done, done_seen;
    logic [31:0] s_wd, prev_wd;
    logic [15:0] s_rem;
    logic [2:0]  s_bv;
    total = n + extra; idx = 0; cyc = 0; wk = 0; pend = 0; pend_last = 0;
    fin = 0; stall_prev = 0; done_seen = 0; prev_wd = '0; pend_cnt = 0;
    @(negedge clk);
    req_wr = 1'b1; req_cnt = 16'(n);
    @(posedge clk);
    requested = n;
    @(negedge clk);
    req_wr = 1'b0;
    chk(remaining == 16'(n), "R2 remaining after write", 32'(remaining), 32'(n));
    chk(shift_en == 1'b1, "R2 shift_en after write", 32'(shift_en), 32'd1);
    while (!fin && cyc < 4000) begin
      if (cyc != 0) @(negedge clk);
      s_se = shift_en; s_wv = word_valid; s_wd = word_data; s_rem = remaining;
      s_done = rx_done; s_bv = byte_valid;
      chk(s_rem == 16'(requested - idx / 8), "R5 remaining count", 32'(s_rem), 32'(requested - idx / 8));
      if (stall_prev) begin
        chk(s_wv && s_wd == prev_wd, "R8 word held under stall", s_wd, prev_wd);
        chk(!s_se, "R8 shift paused", 32'(s_se), 32'd0);
      end
      if (pend) begin
        chk(s_bv == 3'(pend_cnt), pend_cnt == 4 ? "R7 byte_valid full" : "R6 byte_valid partial",
            32'(s_bv), 32'(pend_cnt));
        chk(s_done == pend_last, "R9 done pulse timing", 32'(s_done), 32'(pend_last));
        if (pend_last) begin
          chk(s_rem == 0 && !s_wv, "R9 idle at done", 32'(s_rem), 32'd0);
          done_seen = 1;
        end
        pend = 0;
      end else if (done_seen) begin
        chk(!s_done, "R9 done single cycle", 32'(s_done), 32'd0);
        fin = 1;
      end else begin
        chk(!s_done, "R9 no early done", 32'(s_done), 32'd0);
      end
      case (mode)
        0: rdy = 1'b1;
        1: rdy = (cyc % 3 == 0);
        default: rdy = ((cyc / 10) % 2 == 1);
      endcase
      word_ready = rdy;
      bit_stb = (mode == 1) ? (cyc % 4 != 1) : 1'b1;
      bit_din = (idx < total * 8) ? dbyte(n, idx / 8)[7 - idx % 8] : 1'b0;
      req_wr = (extra != 0 && cyc == extra_at);
      req_cnt = 16'(extra);
      if (s_wv && rdy) begin
        chk(s_wd == exp_word(n, total, wk), (total - 4 * wk) >= 4 ? "R4 full word" : "R6 partial word",
            s_wd, exp_word(n, total, wk));
        pend = 1;
        pend_cnt = (total - 4 * wk) >= 4 ? 4 : total - 4 * wk;
        pend_last = (4 * wk + pend_cnt >= total);
        wk++;
      end
      stall_prev = s_wv && !rdy;
      prev_wd = s_wd;
      @(posedge clk);
      if (s_se && bit_stb) idx++;
      if (req_wr) requested += extra;
      cyc++;
    end
    req_wr = 1'b0;
    if (!fin) chk(1'b0, "R9 watchdog", 32'(cyc), 32'd0);
    chk(wk == (total + 3) / 4, "R10 word count", 32'(wk), 32'((total + 3) / 4));
  endtask

  initial begin
    do_reset();
    chk(remaining == 0 && !shift_en && !word_valid && !rx_done && byte_valid == 0,
        "R1 reset state", {remaining, 13'd0, byte_valid}, 32'd0);

    req_wr = 1'b1; req_cnt = 16'd0;
    @(negedge clk); req_wr = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(remaining == 0 && !shift_en && !word_valid, "R3 zero request ignored",
          32'(remaining), 32'd0);
      @(negedge clk);
    end

    for (int n = 1; n <= 13; n++)
      for (int m = 0; m < 3; m++) run_xfer(n, m, 0, 0);

    run_xfer(5, 0, 3, 12);
    run_xfer(2, 2, 9, 5);

    do_reset();
    bit_stb = 1'b0;
    req_wr = 1'b1; req_cnt = 16'hFFF0;
    @(negedge clk); req_cnt = 16'h0100;
    @(negedge clk); req_wr = 1'b0;
    chk(remaining == 16'hFFFF, "R10 saturating add", 32'(remaining), 32'hFFFF);
    do_reset();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule